// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

This block gathers thirty-two active-high, level-sensitive interrupt sources into one status word and fans them out to four output lines: a normal interrupt line and a machine-check line for each of two processor cores. Each of the four lines has its own 32-bit enable mask. A line is asserted while at least one source is both high and enabled in that line's mask. There is no acknowledge and nothing is latched. Software clears an interrupt by quietening the source or by clearing the mask bit.

Software reaches the block over a plain single-cycle register bus with byte addresses. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. The raw inputs are first resynchronised by two flops. The four outputs are registered. A convenience register reports the highest-numbered source that is pending for core 0's normal line, so a handler can find its source with a single read.

Top module: `irqagg_top`

## Requirements
- R1: The status register at byte address 0x00 reads the synchronised input levels, bit i for input i. A change on the inputs shows there two clock edges later. Writes to 0x00 change nothing.
- R2: The normal-line masks sit at 0x10 (core 0) and 0x14 (core 1). Each reads back exactly the last 32-bit value written to it and is zero after reset.
- R3: The machine-check masks sit at 0x18 (core 0) and 0x1C (core 1). Each reads back exactly the last 32-bit value written to it and is zero after reset.
- R4: coreIrq[n] equals the OR of (status AND normal mask n). It is registered, so it follows a status or mask change one edge later, which is three edges after an input change.
- R5: coreMchk[n] equals the OR of (status AND machine-check mask n), with the same one-edge registration.
- R6: No exclusivity is enforced. A single source enabled in several masks drives all of the matching lines at once.
- R7: There is no acknowledge. A line drops only when its enabled sources go low or their mask bits are cleared.
- R8: Address 0x20 is read-only. When (status AND normal mask 0) is nonzero, it reads bit 31 = 1 with the index of the highest set bit in bits 4:0. Otherwise it reads zero.
- R9: Reads of any other address, including misaligned ones, return zero. Writes to them change no register.
- R10: While reset is asserted, and right after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw level interrupt sources |
| busAddr | input | 8 | Byte address for read and write |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| coreIrq | output | 2 | Normal interrupt line per core |
| coreMchk | output | 2 | Machine-check line per core |

## Verification
A corrupted mask register shows up at once on a read of its address. It also shows up one edge later as a wrong output level, as soon as a source covered by the bad bit is high. A synchroniser stage that is stuck or skipped shifts the status readback and all four outputs by a whole cycle against the two- and three-edge latencies. The bench checks those latencies at the exact edges. A wrong decode shows up as data leaking into unmapped reads, or as a mask changing after a write to some other address.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  // byte offsets; the mask banks are indexed by core number
  localparam int unsigned OFF_STATUS   = 'h00;
  localparam int unsigned OFF_IRQMASK  = 'h10;
  localparam int unsigned OFF_MCHKMASK = 'h18;
  localparam int unsigned OFF_HIGHEST  = 'h20;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_IRQMASK,
    RD_MCHKMASK,
    RD_HIGHEST
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CORES-1:0] wrIrqMask;
    logic [NUM_CORES-1:0] wrMchkMask;
    rdSel_e               rdSel;
    logic [CORE_W-1:0]    rdCore;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes            = '0;
    strobes.rdSel      = RD_NONE;
    if (busAddr == ADDR_W'(OFF_STATUS))  strobes.rdSel = RD_STATUS;
    if (busAddr == ADDR_W'(OFF_HIGHEST)) strobes.rdSel = RD_HIGHEST;
    for (int n = 0; n < int'(NUM_CORES); n++) begin
      if (busAddr == ADDR_W'(OFF_IRQMASK + 4 * n)) begin
        strobes.rdSel        = RD_IRQMASK;
        strobes.rdCore       = CORE_W'(n);
        strobes.wrIrqMask[n] = busWrEn;
      end
      if (busAddr == ADDR_W'(OFF_MCHKMASK + 4 * n)) begin
        strobes.rdSel         = RD_MCHKMASK;
        strobes.rdCore        = CORE_W'(n);
        strobes.wrMchkMask[n] = busWrEn;
      end
    end
  end
endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_SRC-1:0]                  irqIn,
  input  logic [DATA_W-1:0]                   busWrData,
  input  ctrlStrobes_t                        strobes,
  output logic [DATA_W-1:0]                   busRdData,
  output logic [NUM_SRC-1:0]                  statusQ,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0]   irqMaskQ,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0]   mchkMaskQ,
  output logic [NUM_CORES-1:0]                coreIrq,
  output logic [NUM_CORES-1:0]                coreMchk
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] syncStage;
  logic [NUM_SRC-1:0] pending0;
  logic [IDX_W-1:0]   topIdx;
  logic               anyPending0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= '0;
      statusQ   <= '0;
    end else begin
      syncStage <= irqIn;
      statusQ   <= syncStage;
    end
  end

  for (genvar n = 0; n < int'(NUM_CORES); n++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqMaskQ[n]  <= '0;
        mchkMaskQ[n] <= '0;
        coreIrq[n]   <= 1'b0;
        coreMchk[n]  <= 1'b0;
      end else begin
        if (strobes.wrIrqMask[n])  irqMaskQ[n]  <= busWrData[NUM_SRC-1:0];
        if (strobes.wrMchkMask[n]) mchkMaskQ[n] <= busWrData[NUM_SRC-1:0];
        coreIrq[n]  <= |(statusQ & irqMaskQ[n]);
        coreMchk[n] <= |(statusQ & mchkMaskQ[n]);
      end
    end
  end

  assign pending0 = statusQ & irqMaskQ[0];

  always_comb begin
    topIdx      = '0;
    anyPending0 = 1'b0;
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (pending0[i]) begin
        topIdx      = IDX_W'(i);
        anyPending0 = 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (strobes.rdSel)
      RD_STATUS:   busRdData[NUM_SRC-1:0] = statusQ;
      RD_IRQMASK:  busRdData[NUM_SRC-1:0] = irqMaskQ[strobes.rdCore];
      RD_MCHKMASK: busRdData[NUM_SRC-1:0] = mchkMaskQ[strobes.rdCore];
      RD_HIGHEST: begin
        busRdData[DATA_W-1]  = anyPending0;
        busRdData[IDX_W-1:0] = topIdx;
      end
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES-1:0] coreMchk
);
  ctrlStrobes_t                       strobes;
  logic [NUM_SRC-1:0]                 statusW;
  logic [NUM_CORES-1:0][NUM_SRC-1:0]  irqMaskW;
  logic [NUM_CORES-1:0][NUM_SRC-1:0]  mchkMaskW;

  irqagg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  irqagg_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .busWrData (busWrData),
    .strobes   (strobes),
    .busRdData (busRdData),
    .statusQ   (statusW),
    .irqMaskQ  (irqMaskW),
    .mchkMaskQ (mchkMaskW),
    .coreIrq   (coreIrq),
    .coreMchk  (coreMchk)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [NUM_SRC-1:0]                 irqIn,
  input logic [ADDR_W-1:0]                  busAddr,
  input logic                               busWrEn,
  input logic [DATA_W-1:0]                  busRdData,
  input logic [NUM_CORES-1:0]               coreIrq,
  input logic [NUM_CORES-1:0]               coreMchk,
  input logic [NUM_SRC-1:0]                 statusW,
  input logic [NUM_CORES-1:0][NUM_SRC-1:0]  irqMaskW,
  input logic [NUM_CORES-1:0][NUM_SRC-1:0]  mchkMaskW
);
  logic [1:0] upCnt;
  logic       mapped;
  logic [NUM_SRC-1:0] pend0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  always_comb begin
    mapped = (busAddr == ADDR_W'(OFF_STATUS)) || (busAddr == ADDR_W'(OFF_HIGHEST));
    for (int n = 0; n < int'(NUM_CORES); n++) begin
      if (busAddr == ADDR_W'(OFF_IRQMASK + 4 * n))  mapped = 1'b1;
      if (busAddr == ADDR_W'(OFF_MCHKMASK + 4 * n)) mapped = 1'b1;
    end
  end

  assign pend0 = statusW & irqMaskW[0];

  AST_STATUS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2) |-> (statusW == $past(irqIn, 2))); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(irqMaskW) && $stable(mchkMaskW))); // R2

  for (genvar n = 0; n < int'(NUM_CORES); n++) begin : g_out
    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd1) |-> (coreIrq[n] == $past(|(statusW & irqMaskW[n])))); // R4
    AST_MCHK_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd1) |-> (coreMchk[n] == $past(|(statusW & mchkMaskW[n])))); // R5
  end

  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd0) |-> ((coreIrq == '0) && (coreMchk == '0))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (busRdData == '0)); // R9

  AST_HIGHEST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ((busAddr == ADDR_W'(OFF_HIGHEST)) && busRdData[DATA_W-1])
      |-> pend0[busRdData[$clog2(NUM_SRC)-1:0]]); // R8
endmodule

bind irqagg_top irqagg_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .coreIrq   (coreIrq),
  .coreMchk  (coreMchk),
  .statusW   (statusW),
  .irqMaskW  (irqMaskW),
  .mchkMaskW (mchkMaskW)
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [1:0]  coreIrq;
  logic [1:0]  coreMchk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  irqagg_top u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .coreIrq(coreIrq), .coreMchk(coreMchk)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] im0;
    logic [31:0] im1;
    logic [31:0] mm0;
    logic [31:0] mm1;
    logic [3:0]  expOut; // {mchk1, mchk0, irq1, irq0}
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 4'b0001},
    '{32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0, 32'h0, 4'b0010},
    '{32'h0000_00F0, 32'h0, 32'h0, 32'h0000_0010, 32'h0, 4'b0100},
    '{32'h0000_0100, 32'h0, 32'h0, 32'h0, 32'h0000_0100, 4'b1000},
    '{32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 4'b1111},
    '{32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0, 32'h0, 4'b0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'hFF;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] highestOf(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 31; i >= 0; i--) if (v[i]) begin r = 32'h8000_0000 | 32'(i); break; end
    return r;
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    // R10: outputs low during reset
    repeat (3) @(negedge clk);
    check("R10 outputs in reset", {28'h0, coreMchk, coreIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outputs after reset", {28'h0, coreMchk, coreIrq}, 32'h0);
    busRead(8'h10, rd); check("R2 irq mask0 reset", rd, 32'h0);
    busRead(8'h14, rd); check("R2 irq mask1 reset", rd, 32'h0);
    busRead(8'h18, rd); check("R3 mchk mask0 reset", rd, 32'h0);
    busRead(8'h1C, rd); check("R3 mchk mask1 reset", rd, 32'h0);
    busRead(8'h20, rd); check("R8 highest empty", rd, 32'h0);

    // table walk: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      busWrite(8'h10, VECS[v].im0);
      busWrite(8'h14, VECS[v].im1);
      busWrite(8'h18, VECS[v].mm0);
      busWrite(8'h1C, VECS[v].mm1);
      @(negedge clk); irqIn = VECS[v].src;
      repeat (3) @(negedge clk);
      check($sformatf("R4/R5/R6 vector %0d outputs", v), {28'h0, coreMchk, coreIrq},
            {28'h0, VECS[v].expOut});
      busRead(8'h00, rd); check($sformatf("R1 vector %0d status", v), rd, VECS[v].src);
      busRead(8'h20, rd);
      check($sformatf("R8 vector %0d highest", v), rd, highestOf(VECS[v].src & VECS[v].im0));
      busRead(8'h10, rd); check($sformatf("R2 vector %0d readback", v), rd, VECS[v].im0);
      busRead(8'h1C, rd); check($sformatf("R3 vector %0d readback", v), rd, VECS[v].mm1);
      @(negedge clk); irqIn = '0;
      repeat (3) @(negedge clk);
    end

    // R1 and R4 latency, edge by edge
    busWrite(8'h10, 32'h0000_0004);
    @(negedge clk); irqIn = 32'h0000_0004;
    @(negedge clk);
    busAddr = 8'h00; #1 check("R1 status not yet after 1 edge", busRdData, 32'h0);
    @(negedge clk);
    #1 check("R1 status after 2 edges", busRdData, 32'h4);
    check("R4 line still low after 2 edges", {31'h0, coreIrq[0]}, 32'h0);
    @(negedge clk);
    check("R4 line high after 3 edges", {31'h0, coreIrq[0]}, 32'h1);

    // R7: no acknowledge; stays up until mask cleared
    repeat (5) @(negedge clk);
    check("R7 line held without ack", {31'h0, coreIrq[0]}, 32'h1);
    busWrite(8'h10, 32'h0);
    check("R7 line not dropped before mask edge+1", {31'h0, coreIrq[0]}, 32'h1);
    @(negedge clk);
    check("R7 line low after mask clear", {31'h0, coreIrq[0]}, 32'h0);

    // R7: drop through the source
    busWrite(8'h18, 32'h0000_0004);
    @(negedge clk);
    check("R5 mchk0 high", {31'h0, coreMchk[0]}, 32'h1);
    irqIn = '0;
    repeat (3) @(negedge clk);
    check("R7 mchk0 low after source drop", {31'h0, coreMchk[0]}, 32'h0);

    // R1: writes to status are ignored
    irqIn = 32'h0000_0A00;
    busWrite(8'h00, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    busRead(8'h00, rd); check("R1 status write ignored", rd, 32'h0000_0A00);

    // R9: unmapped reads and writes
    busWrite(8'h14, 32'h1234_5678);
    busWrite(8'h0C, 32'hDEAD_BEEF);
    busWrite(8'h11, 32'hDEAD_BEEF);
    busWrite(8'h24, 32'hDEAD_BEEF);
    busRead(8'h14, rd); check("R9 mask1 untouched by unmapped writes", rd, 32'h1234_5678);
    busRead(8'h10, rd); check("R9 mask0 untouched by unmapped writes", rd, 32'h0);
    busRead(8'h0C, rd); check("R9 unmapped 0x0C reads zero", rd, 32'h0);
    busRead(8'h11, rd); check("R9 misaligned 0x11 reads zero", rd, 32'h0);
    busRead(8'h24, rd); check("R9 unmapped 0x24 reads zero", rd, 32'h0);

    // R8: highest picks top bit among several; ignores core-1 mask
    busWrite(8'h10, 32'h0000_0A00);
    busRead(8'h20, rd); check("R8 highest of 9 and 11", rd, 32'h8000_000B);
    busWrite(8'h10, 32'h0000_0200);
    busRead(8'h20, rd); check("R8 highest with partial mask", rd, 32'h8000_0009);
    busWrite(8'h10, 32'h0);
    busRead(8'h20, rd); check("R8 highest ignores other masks", rd, 32'h0);

    // R10: reset mid-run clears masks and outputs
    busWrite(8'h1C, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R5 mchk1 high before reset", {31'h0, coreMchk[1]}, 32'h1);
    rstN = 1'b0;
    #1 check("R10 outputs low in reset", {28'h0, coreMchk, coreIrq}, 32'h0);
    @(negedge clk); rstN = 1'b1; irqIn = '0;
    busRead(8'h1C, rd); check("R3 mask cleared by reset", rd, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule